// File: doc/BRIEF.md
# Atomic Swap Bus Sequencer

This block runs the external memory bus for one indivisible read-then-write swap operation in a small pipelined processor. A one-clock start pulse brings in the program counter, the base address, the store value, a byte/word size code and the index of the destination register. The block then walks a fixed schedule of four bus cycles. Each cycle has its own address, transfer size, direction, request, sequential, opcode-fetch and lock values.

In the second cycle the block reads memory at the base address. In the third cycle it writes the store value back to that same address. The lock output stays high across exactly that pair, so no other master can take the bus between the read and the write. The data read in the second cycle is kept in a holding register. In the fourth cycle it is handed to the register file through a one-clock write strobe. That strobe is suppressed if an abort was reported in the read or the write cycle.

A size code that is not byte or word is refused at the start. The block raises an error pulse and makes no bus access.

Top module: `swap_seq`

## Requirements
- R1: A start pulse with a legal size, taken while `busy` is low, produces exactly four cycles with `busy` high. These begin on the clock after the pulse, and then `busy` returns low.
- R2: Cycle 1 drives the address `pc+8` (modulo 2^AW), size code 2'b10 (word), read direction, `mem_req` high, `seq` low, `opfetch` high, `lock` low and `wdata` zero.
- R3: Cycle 2 drives the base address, the selected size code, read direction, `mem_req` high, `seq` low, `opfetch` low, `lock` high and `wdata` zero.
- R4: Cycle 3 drives the base address, the selected size code, write direction (`wr` high) and the store value on `wdata`, with `mem_req` low, `seq` low, `opfetch` low and `lock` high.
- R5: Cycle 4 drives the address `pc+12` (modulo 2^AW), word size, read direction, `mem_req` high, `seq` high, `opfetch` low, `lock` low and `wdata` zero.
- R6: `lock` is high only in cycles 2 and 3, and it is always high for exactly those two cycles back to back.
- R7: Size codes are 2'b00 byte, 2'b10 word, 2'b01 halfword and 2'b11 reserved. A start carrying 2'b01 or 2'b11 gives a one-clock `err` pulse on the next clock. In that case `busy` and `mem_req` stay low and every bus output stays at its idle value.
- R8: `rdata` is sampled on the clock edge that ends cycle 2. In cycle 4, `rf_we` is high for one clock with `rf_wdata` equal to that sample and `rf_waddr` equal to the destination index given at the start.
- R9: If `abort` is high in cycle 2 or in cycle 3, `rf_we` stays low for the whole operation.
- R10: A start pulse that arrives while `busy` is high is ignored. The operation in progress keeps its schedule and operands, and no extra operation follows it.
- R11: A synchronous active-high `rst` puts the block in idle. In idle, `busy`, `err`, `lock`, `mem_req`, `wr` and `rf_we` are low, and address, size and `wdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-clock request to begin a swap |
| pc | input | AW | Program counter of the swap instruction |
| base | input | AW | Memory address to swap at |
| src | input | DW | Value to store |
| size | input | 2 | Transfer size code |
| dest | input | RW | Destination register index |
| rdata | input | DW | Memory read data |
| abort | input | 1 | Memory abort for the current cycle |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Illegal size refused |
| addr | output | AW | Bus address |
| bus_size | output | 2 | Bus transfer size code |
| wr | output | 1 | Write direction |
| mem_req | output | 1 | Memory request for the next cycle |
| seq | output | 1 | Sequential access indication |
| opfetch | output | 1 | Opcode fetch indication |
| lock | output | 1 | Bus lock |
| wdata | output | DW | Write data |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | RW | Register-file write index |
| rf_wdata | output | DW | Register-file write data |

## Verification
The assertions assume that `abort` is only meaningful during cycles 2 and 3. They also assume that `rst` is held for at least one clock before the first start, so the lock and write relations can be traced from a known idle state. The stimulus drives start pulses only from idle or as deliberate collisions with a running operation. It raises `abort` only inside the read or write cycle, and it changes `rdata` after cycle 2 to expose the capture edge.

// File: rtl/swp_pkg.sv
package swp_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_FETCH = 3'd1,
        PH_READ  = 3'd2,
        PH_WRITE = 3'd3,
        PH_NEXT  = 3'd4
    } phase_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    function automatic logic size_legal(input logic [1:0] s);
        return (s == SZ_BYTE) || (s == SZ_WORD);
    endfunction

endpackage

// File: rtl/swp_sched.sv
module swp_sched
    import swp_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] src,
    input  logic [1:0]    size,
    input  logic [RW-1:0] dest,
    output phase_e        phase,
    output logic [AW-1:0] pc_q,
    output logic [AW-1:0] base_q,
    output logic [DW-1:0] src_q,
    output logic [1:0]    size_q,
    output logic [RW-1:0] dest_q,
    output logic          err
);

    typedef struct packed {
        phase_e        ph;
        logic [AW-1:0] pc;
        logic [AW-1:0] base;
        logic [DW-1:0] src;
        logic [1:0]    sz;
        logic [RW-1:0] dst;
        logic          err;
    } sched_t;

    sched_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    if (size_legal(size)) begin
                        st_d.ph   = PH_FETCH;
                        st_d.pc   = pc;
                        st_d.base = base;
                        st_d.src  = src;
                        st_d.sz   = size;
                        st_d.dst  = dest;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
            end
            PH_FETCH: st_d.ph = PH_READ;
            PH_READ:  st_d.ph = PH_WRITE;
            PH_WRITE: st_d.ph = PH_NEXT;
            PH_NEXT:  st_d.ph = PH_IDLE;
            default:  st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ph: PH_IDLE, pc: '0, base: '0, src: '0, sz: '0, dst: '0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase  = st_q.ph;
    assign pc_q   = st_q.pc;
    assign base_q = st_q.base;
    assign src_q  = st_q.src;
    assign size_q = st_q.sz;
    assign dest_q = st_q.dst;
    assign err    = st_q.err;

endmodule

// File: rtl/swp_busdec.sv
module swp_busdec
    import swp_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int FETCH_OFS  = 8,
    parameter int NEXT_OFS   = 12
) (
    input  phase_e        phase,
    input  logic [AW-1:0] pc_q,
    input  logic [AW-1:0] base_q,
    input  logic [DW-1:0] src_q,
    input  logic [1:0]    size_q,
    output logic [AW-1:0] addr,
    output logic [1:0]    bus_size,
    output logic          wr,
    output logic          mem_req,
    output logic          seq,
    output logic          opfetch,
    output logic          lock,
    output logic [DW-1:0] wdata
);

    localparam logic [AW-1:0] FETCH_STEP = AW'(FETCH_OFS);
    localparam logic [AW-1:0] NEXT_STEP  = AW'(NEXT_OFS);

    always_comb begin
        addr     = '0;
        bus_size = 2'b00;
        wr       = 1'b0;
        mem_req  = 1'b0;
        seq      = 1'b0;
        opfetch  = 1'b0;
        lock     = 1'b0;
        wdata    = '0;
        unique case (phase)
            PH_FETCH: begin
                addr     = pc_q + FETCH_STEP;
                bus_size = SZ_WORD;
                mem_req  = 1'b1;
                opfetch  = 1'b1;
            end
            PH_READ: begin
                addr     = base_q;
                bus_size = size_q;
                mem_req  = 1'b1;
                lock     = 1'b1;
            end
            PH_WRITE: begin
                addr     = base_q;
                bus_size = size_q;
                wr       = 1'b1;
                lock     = 1'b1;
                wdata    = src_q;
            end
            PH_NEXT: begin
                addr     = pc_q + NEXT_STEP;
                bus_size = SZ_WORD;
                mem_req  = 1'b1;
                seq      = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/swp_wb.sv
module swp_wb
    import swp_pkg::*;
#(
    parameter int DW = 32,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase,
    input  logic [DW-1:0] rdata,
    input  logic          abort,
    input  logic [RW-1:0] dest_q,
    output logic          rf_we,
    output logic [RW-1:0] rf_waddr,
    output logic [DW-1:0] rf_wdata
);

    typedef struct packed {
        logic [DW-1:0] hold;
        logic          abt;
    } wb_t;

    wb_t wb_d, wb_q;

    always_comb begin
        wb_d = wb_q;
        unique case (phase)
            PH_FETCH: wb_d.abt = 1'b0;
            PH_READ: begin
                wb_d.hold = rdata;
                if (abort) wb_d.abt = 1'b1;
            end
            PH_WRITE: begin
                if (abort) wb_d.abt = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_q <= '{hold: '0, abt: 1'b0};
        end else begin
            wb_q <= wb_d;
        end
    end

    assign rf_we    = (phase == PH_NEXT) && !wb_q.abt;
    assign rf_waddr = dest_q;
    assign rf_wdata = wb_q.hold;

endmodule

// File: rtl/swap_seq.sv
module swap_seq
    import swp_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] src,
    input  logic [1:0]    size,
    input  logic [RW-1:0] dest,
    input  logic [DW-1:0] rdata,
    input  logic          abort,
    output logic          busy,
    output logic          err,
    output logic [AW-1:0] addr,
    output logic [1:0]    bus_size,
    output logic          wr,
    output logic          mem_req,
    output logic          seq,
    output logic          opfetch,
    output logic          lock,
    output logic [DW-1:0] wdata,
    output logic          rf_we,
    output logic [RW-1:0] rf_waddr,
    output logic [DW-1:0] rf_wdata
);

    phase_e        phase;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] base_q;
    logic [DW-1:0] src_q;
    logic [1:0]    size_q;
    logic [RW-1:0] dest_q;

    swp_sched #(.AW(AW), .DW(DW), .RW(RW)) u_sched (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .pc     (pc),
        .base   (base),
        .src    (src),
        .size   (size),
        .dest   (dest),
        .phase  (phase),
        .pc_q   (pc_q),
        .base_q (base_q),
        .src_q  (src_q),
        .size_q (size_q),
        .dest_q (dest_q),
        .err    (err)
    );

    swp_busdec #(.AW(AW), .DW(DW), .FETCH_OFS(8), .NEXT_OFS(12)) u_bus (
        .phase    (phase),
        .pc_q     (pc_q),
        .base_q   (base_q),
        .src_q    (src_q),
        .size_q   (size_q),
        .addr     (addr),
        .bus_size (bus_size),
        .wr       (wr),
        .mem_req  (mem_req),
        .seq      (seq),
        .opfetch  (opfetch),
        .lock     (lock),
        .wdata    (wdata)
    );

    swp_wb #(.DW(DW), .RW(RW)) u_wb (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .rdata    (rdata),
        .abort    (abort),
        .dest_q   (dest_q),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata)
    );

    assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/swap_seq_chk.sv
module swap_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          err,
    input logic [AW-1:0] addr,
    input logic [1:0]    bus_size,
    input logic          wr,
    input logic          mem_req,
    input logic          seq,
    input logic          opfetch,
    input logic          lock,
    input logic          rf_we
);

    // R6: lock never appears outside an operation
    a_r6_lock_busy: assert property (@(posedge clk) disable iff (rst)
        lock |-> busy);

    // R6: the cycle after lock rises is the locked write cycle
    a_r6_lock_pair: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |=> (lock && wr));

    // R6: lock falls after the write cycle
    a_r6_lock_drop: assert property (@(posedge clk) disable iff (rst)
        (lock && wr) |=> !lock);

    // R3: first locked cycle is a read with request
    a_r3_read_cycle: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> (!wr && mem_req && !opfetch && !seq));

    // R4: write cycle carries no request for the next cycle
    a_r4_write_noreq: assert property (@(posedge clk) disable iff (rst)
        wr |-> (!mem_req && lock && !seq));

    // R2: opcode fetch is an unlocked word read
    a_r2_fetch_word: assert property (@(posedge clk) disable iff (rst)
        opfetch |-> (busy && !lock && !wr && bus_size == 2'b10));

    // R5: the sequential cycle follows the locked write
    a_r5_seq_after_write: assert property (@(posedge clk) disable iff (rst)
        (lock && wr) |=> (seq && mem_req && bus_size == 2'b10));

    // R8: writeback strobe only in the sequential cycle
    a_r8_we_in_last: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (seq && busy));

    // R1: operation ends right after the sequential cycle
    a_r1_end_after_seq: assert property (@(posedge clk) disable iff (rst)
        seq |=> !busy);

    // R7: a refused request leaves the bus quiet
    a_r7_err_quiet: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && !mem_req && !lock));

    // R7: error is a single-clock pulse
    a_r7_err_pulse: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

endmodule

bind swap_seq swap_seq_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .err      (err),
    .addr     (addr),
    .bus_size (bus_size),
    .wr       (wr),
    .mem_req  (mem_req),
    .seq      (seq),
    .opfetch  (opfetch),
    .lock     (lock),
    .rf_we    (rf_we)
);

// File: tb/sim_swap_seq.sv
`timescale 1ns/1ps
module sim_swap_seq;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int RW = 4;
    localparam int BW = AW + 2 + 5 + DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] pc = '0;
    logic [AW-1:0] base = '0;
    logic [DW-1:0] src = '0;
    logic [1:0]    size = '0;
    logic [RW-1:0] dest = '0;
    logic [DW-1:0] rdata = '0;
    logic          abort = 1'b0;
    logic          busy, err, wr, mem_req, seq, opfetch, lock, rf_we;
    logic [AW-1:0] addr;
    logic [1:0]    bus_size;
    logic [DW-1:0] wdata, rf_wdata;
    logic [RW-1:0] rf_waddr;

    always #5 clk = ~clk;

    swap_seq #(.AW(AW), .DW(DW), .RW(RW)) u0 (
        .clk(clk), .rst(rst), .start(start), .pc(pc), .base(base), .src(src),
        .size(size), .dest(dest), .rdata(rdata), .abort(abort), .busy(busy),
        .err(err), .addr(addr), .bus_size(bus_size), .wr(wr), .mem_req(mem_req),
        .seq(seq), .opfetch(opfetch), .lock(lock), .wdata(wdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // fields: pc, base, src, rdata, size, dest, abort_read, abort_write
    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] base;
        logic [31:0] src;
        logic [31:0] rd;
        logic [1:0]  sz;
        logic [3:0]  dst;
        logic        ab_r;
        logic        ab_w;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_0100, 32'h0000_2000, 32'hDEAD_BEEF, 32'h1234_5678, 2'b10, 4'd3,  1'b0, 1'b0},
        '{32'h0000_0400, 32'h0000_3001, 32'h0000_00A5, 32'h0000_005A, 2'b00, 4'd7,  1'b0, 1'b0},
        '{32'h0000_0800, 32'h0000_4000, 32'hCAFE_F00D, 32'h0BAD_0BAD, 2'b10, 4'd1,  1'b1, 1'b0},
        '{32'h0000_0C00, 32'h0000_5002, 32'h0000_0011, 32'h0000_0022, 2'b00, 4'd9,  1'b0, 1'b1},
        '{32'h0000_1000, 32'h0000_6000, 32'h1111_2222, 32'h3333_4444, 2'b10, 4'd2,  1'b1, 1'b1},
        '{32'hFFFF_FFF8, 32'hFFFF_FFFC, 32'h8765_4321, 32'hA5A5_5A5A, 2'b10, 4'd15, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] bus_now();
        return {addr, bus_size, wr, mem_req, seq, opfetch, lock, wdata};
    endfunction

    function automatic logic [BW-1:0] bus_exp(input logic [AW-1:0] a, input logic [1:0] s,
        input bit w, input bit m, input bit q, input bit o, input bit l, input logic [DW-1:0] d);
        return {a, s, w, m, q, o, l, d};
    endfunction

    task automatic check_idle(input string tag);
        chk(bus_now() == '0 && !busy && !rf_we, tag, BW'({busy, rf_we, bus_now()}), '0);
    endtask

    // collide: assert a second start during the read cycle
    task automatic run_swap(input vec_t v, input bit collide);
        @(negedge clk);
        start = 1'b1; pc = v.pc; base = v.base; src = v.src; size = v.sz; dest = v.dst;
        @(negedge clk);
        start = 1'b0; pc = ~v.pc; base = ~v.base; src = ~v.src; dest = ~v.dst;
        // cycle 1
        chk(busy, "R1 busy c1", BW'(busy), BW'(1));
        chk(bus_now() == bus_exp(v.pc + 32'd8, 2'b10, 0, 1, 0, 1, 0, '0), "R2 fetch cycle",
            bus_now(), bus_exp(v.pc + 32'd8, 2'b10, 0, 1, 0, 1, 0, '0));
        chk(!lock, "R6 lock c1", BW'(lock), BW'(0));
        chk(!rf_we, "R8 no strobe c1", BW'(rf_we), BW'(0));
        @(negedge clk);
        // cycle 2
        rdata = v.rd; abort = v.ab_r;
        if (collide) begin
            start = 1'b1; size = 2'b00;
        end
        chk(bus_now() == bus_exp(v.base, v.sz, 0, 1, 0, 0, 1, '0), "R3 read cycle",
            bus_now(), bus_exp(v.base, v.sz, 0, 1, 0, 0, 1, '0));
        chk(lock, "R6 lock c2", BW'(lock), BW'(1));
        @(negedge clk);
        // cycle 3
        start = 1'b0;
        rdata = ~v.rd; abort = v.ab_w;
        chk(bus_now() == bus_exp(v.base, v.sz, 1, 0, 0, 0, 1, v.src), "R4 write cycle",
            bus_now(), bus_exp(v.base, v.sz, 1, 0, 0, 0, 1, v.src));
        chk(lock, "R6 lock c3", BW'(lock), BW'(1));
        @(negedge clk);
        // cycle 4
        abort = 1'b0;
        chk(bus_now() == bus_exp(v.pc + 32'd12, 2'b10, 0, 1, 1, 0, 0, '0), "R5 next cycle",
            bus_now(), bus_exp(v.pc + 32'd12, 2'b10, 0, 1, 1, 0, 0, '0));
        chk(!lock, "R6 lock c4", BW'(lock), BW'(0));
        if (v.ab_r || v.ab_w) begin
            chk(!rf_we, "R9 abort blocks writeback", BW'(rf_we), BW'(0));
        end else begin
            chk(rf_we && rf_wdata == v.rd && rf_waddr == v.dst, "R8 writeback",
                BW'({rf_we, rf_waddr, rf_wdata}), BW'({1'b1, v.dst, v.rd}));
        end
        @(negedge clk);
        check_idle(collide ? "R10 no extra operation" : "R1 idle after c4");
        @(negedge clk);
        check_idle(collide ? "R10 still idle" : "R1 still idle");
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        check_idle("R11 reset idle");
        chk(!err && !lock, "R11 reset flags", BW'({err, lock}), '0);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R11 idle after release");

        for (int i = 0; i < NV; i++) begin
            run_swap(VEC[i], 1'b0);
        end

        // R10: start during a running operation
        run_swap(VEC[0], 1'b1);

        // R7: illegal size codes
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            start = 1'b1; size = (k == 0) ? 2'b01 : 2'b11; pc = 32'h40; base = 32'h80;
            @(negedge clk);
            start = 1'b0;
            chk(err && !busy && !mem_req && bus_now() == '0, "R7 illegal size refused",
                BW'({err, busy, bus_now()}), BW'({1'b1, 1'b0, {BW{1'b0}}}) );
            @(negedge clk);
            chk(!err && !busy, "R7 error pulse ends", BW'({err, busy}), '0);
        end

        // R11: reset in the middle of an operation
        @(negedge clk);
        start = 1'b1; size = 2'b10; pc = 32'h200; base = 32'h900;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(lock, "R6 lock before reset", BW'(lock), BW'(1));
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_idle("R11 reset mid operation");
        chk(!lock && !err, "R11 lock cleared", BW'({lock, err}), '0);
        @(negedge clk);
        check_idle("R11 stays idle");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule